// File: doc/BRIEF.md
# Fractional Jitter Baud Generator

This block produces the per-bit timing strobe of a serial line from a fast sampling clock. A programmable divisor `divisorReg` holds the divide ratio minus one, so the ratio is D = `divisorReg` + 1. A prescaler turns the clock into sub-ticks that are D cycles apart. A nominal bit spans 16 sub-ticks, so it lasts 16·D clock cycles.

A per-position jitter word can widen or narrow any single bit of the frame by one sub-tick, which is D cycles or 1/16 of a bit. Software spreads these corrections across the frame so that the accumulated timing error stays small even when the clock is not an exact multiple of the line rate. The transmit side and the receive side each keep their own pattern word, so each side instantiates its own copy of the block.

A one-cycle `frameStart` pulse begins a frame. The frame length is worked out from the line settings. The block then steps a bit index through the frame. In transmit mode the strobe marks the end of every bit; in receive mode it marks the middle of every bit. The serializer that consumes the strobe is a separate block.

Top module: `jitter_baud_gen`

## Requirements
- R1: After reset, `bitStrobe` is 0, `frameActive` is 0 and `bitIndex` is 0.
- R2: The frame length is L = 1 + (5 + `dataBitsSel`) + P + (1 + `stopBitsSel`). P is 1 when `paritySel` is nonzero and 0 when it is 0; `paritySel` values 1 to 4 mean even, odd, forced one and forced zero. `frameActive` is high for exactly the sum of the L bit widths and then falls.
- R3: Bit i is nominal when its code is 00. A nominal bit lasts 16·D cycles, with D = `divisorReg` + 1 and D ranging from 1 to 256.
- R4: The 2-bit code for bit position i sits in `jitterPattern[2i+1:2i]`, for i from 0 to 11. Code 01 makes bit i last 17·D cycles. Code 10 makes it last 15·D cycles. Codes 00 and 11 leave it at 16·D cycles.
- R5: In transmit mode (`rxMode` = 0), `bitStrobe` is high for one cycle at the last clock cycle of each bit. For a `frameStart` sampled at clock edge k, the strobe for bit i appears in the cycle that follows edge k + T_i − 1, where T_i is the sum of the widths of bits 0 through i.
- R6: In receive mode (`rxMode` = 1), `bitStrobe` is high for one cycle in the cycle that follows edge k + T_(i−1) + floor(S_i/2)·D − 1. Here S_i is 15, 16 or 17, the number of sub-ticks in bit i, and T_(−1) = 0.
- R7: `bitIndex` is 0 in the cycle after `frameStart` and rises by one at each bit boundary. After the frame ends it holds L − 1 until the next `frameStart`.
- R8: A `frameStart` during an active frame abandons that frame. Timing then restarts from bit 0 exactly as from idle.
- R9: Codes at positions L and above have no effect on the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divisorReg | input | 8 | Divide ratio minus one |
| jitterPattern | input | 24 | Twelve 2-bit width codes, position i at bits 2i+1:2i |
| dataBitsSel | input | 2 | Data bits minus five |
| paritySel | input | 3 | 0 none, 1 even, 2 odd, 3 forced one, 4 forced zero |
| stopBitsSel | input | 1 | Stop bits minus one |
| rxMode | input | 1 | 1 selects mid-bit strobes, 0 selects end-of-bit strobes |
| frameStart | input | 1 | One-cycle pulse that begins a frame |
| bitStrobe | output | 1 | Timing strobe for the serializer |
| bitIndex | output | 4 | Position of the current bit in the frame |
| frameActive | output | 1 | High while a frame is being timed |

## Verification
Directed frames use an all-nominal pattern, an all-widen pattern, an all-narrow pattern and the unused code 11. Comparing strobe positions across these separates the three widths and shows that code 11 is decoded as nominal. Running the same patterns in both modes, including D = 1 and D = 256, shows whether the midpoint is rounded from the real sub-tick count of each bit. A pattern that is nonzero only beyond the frame length and a restart part-way through a frame check R9 and R8. Random frames cover mixed codes across every line setting and both modes.

// File: rtl/jbg_pkg.sv
package jbg_pkg;
  parameter int unsigned NOM_SUB = 16;
  localparam int unsigned SUB_W = $clog2(NOM_SUB + 2);

  typedef enum logic [1:0] {
    JIT_NOM = 2'b00,
    JIT_INC = 2'b01,
    JIT_DEC = 2'b10,
    JIT_RSV = 2'b11
  } jitCode_t;

  // control -> datapath
  typedef struct packed {
    logic             clear;
    logic             run;
    logic [SUB_W-1:0] subLast;
    logic [SUB_W-1:0] midLast;
  } ctrlCmd_t;

  // datapath -> control
  typedef struct packed {
    logic subWrap;
    logic midHit;
  } dpEvt_t;
endpackage

// File: rtl/jbg_ctrl.sv
module jbg_ctrl
  import jbg_pkg::*;
#(
  parameter int unsigned MAX_POS = 12,
  parameter int unsigned IDX_W   = $clog2(MAX_POS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   frameStart,
  input  logic [2*MAX_POS-1:0]   jitterPattern,
  input  logic [1:0]             dataBitsSel,
  input  logic [2:0]             paritySel,
  input  logic                   stopBitsSel,
  input  dpEvt_t                 evt,
  output ctrlCmd_t               cmd,
  output logic [IDX_W-1:0]       bitIndex,
  output logic                   frameActive
);
  localparam int unsigned LEN_BASE = 7;

  jitCode_t         codeArr [MAX_POS];
  jitCode_t         curCode;
  logic [IDX_W-1:0] frameLen;
  logic [IDX_W-1:0] lastIdx;
  logic [SUB_W-1:0] subCount;

  for (genvar p = 0; p < MAX_POS; p++) begin : g_code
    assign codeArr[p] = jitCode_t'(jitterPattern[2*p +: 2]);
  end

  assign frameLen = IDX_W'(LEN_BASE) + IDX_W'(dataBitsSel)
                  + IDX_W'(paritySel != 3'd0) + IDX_W'(stopBitsSel);
  assign lastIdx  = frameLen - IDX_W'(1);

  always_comb begin
    curCode = JIT_NOM;
    for (int p = 0; p < MAX_POS; p++) begin
      if (bitIndex == IDX_W'(p)) curCode = codeArr[p];
    end
  end

  always_comb begin
    unique case (curCode)
      JIT_INC: subCount = SUB_W'(NOM_SUB + 1);
      JIT_DEC: subCount = SUB_W'(NOM_SUB - 1);
      default: subCount = SUB_W'(NOM_SUB);
    endcase
  end

  assign cmd.clear   = frameStart;
  assign cmd.run     = frameActive;
  assign cmd.subLast = subCount - SUB_W'(1);
  assign cmd.midLast = (subCount >> 1) - SUB_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameActive <= 1'b0;
      bitIndex    <= '0;
    end else if (frameStart) begin
      frameActive <= 1'b1;
      bitIndex    <= '0;
    end else if (frameActive && evt.subWrap) begin
      if (bitIndex >= lastIdx) frameActive <= 1'b0;
      else                     bitIndex    <= bitIndex + IDX_W'(1);
    end
  end
endmodule

// File: rtl/jbg_dp.sv
module jbg_dp
  import jbg_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisorReg,
  input  ctrlCmd_t         cmd,
  output dpEvt_t           evt
);
  logic [DIV_W-1:0] divCnt;
  logic [SUB_W-1:0] subCnt;
  logic             subTick;

  assign subTick     = cmd.run && (divCnt == divisorReg);
  assign evt.subWrap = subTick && (subCnt == cmd.subLast);
  assign evt.midHit  = subTick && (subCnt == cmd.midLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      subCnt <= '0;
    end else if (cmd.clear || !cmd.run) begin
      divCnt <= '0;
      subCnt <= '0;
    end else if (subTick) begin
      divCnt <= '0;
      subCnt <= evt.subWrap ? '0 : subCnt + SUB_W'(1);
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/jitter_baud_gen.sv
module jitter_baud_gen
  import jbg_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned MAX_POS = 12,
  localparam int unsigned IDX_W  = $clog2(MAX_POS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DIV_W-1:0]     divisorReg,
  input  logic [2*MAX_POS-1:0] jitterPattern,
  input  logic [1:0]           dataBitsSel,
  input  logic [2:0]           paritySel,
  input  logic                 stopBitsSel,
  input  logic                 rxMode,
  input  logic                 frameStart,
  output logic                 bitStrobe,
  output logic [IDX_W-1:0]     bitIndex,
  output logic                 frameActive
);
  ctrlCmd_t cmd;
  dpEvt_t   evt;

  jbg_ctrl #(.MAX_POS(MAX_POS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .jitterPattern(jitterPattern), .dataBitsSel(dataBitsSel),
    .paritySel(paritySel), .stopBitsSel(stopBitsSel), .evt(evt),
    .cmd(cmd), .bitIndex(bitIndex), .frameActive(frameActive)
  );

  jbg_dp #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .divisorReg(divisorReg), .cmd(cmd), .evt(evt)
  );

  assign bitStrobe = rxMode ? evt.midHit : evt.subWrap;
endmodule

// File: rtl/jitter_baud_gen_chk.sv
module jitter_baud_gen_chk #(
  parameter int unsigned MAX_POS = 12,
  parameter int unsigned IDX_W   = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxMode,
  input logic             frameStart,
  input logic             bitStrobe,
  input logic [IDX_W-1:0] bitIndex,
  input logic             frameActive
);
  AST_STROBE_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |-> frameActive); // R5

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (frameActive && bitIndex == '0)); // R8

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> (bitIndex == $past(bitIndex) ||
                     bitIndex == $past(bitIndex) + 1'b1)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!frameActive && !frameStart) |=> (!frameActive && $stable(bitIndex))); // R2

  AST_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    frameActive |-> (bitIndex < IDX_W'(MAX_POS))); // R2

  AST_TX_STEP_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (!rxMode && frameActive && !frameStart && !bitStrobe) |=> $stable(bitIndex)); // R5
endmodule

bind jitter_baud_gen jitter_baud_gen_chk #(.MAX_POS(MAX_POS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .rxMode(rxMode), .frameStart(frameStart),
  .bitStrobe(bitStrobe), .bitIndex(bitIndex), .frameActive(frameActive)
);

// File: tb/jitter_baud_gen_tb.sv
module jitter_baud_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  divisorReg = '0;
  logic [23:0] jitterPattern = '0;
  logic [1:0]  dataBitsSel = '0;
  logic [2:0]  paritySel = '0;
  logic        stopBitsSel = 1'b0;
  logic        rxMode = 1'b0;
  logic        frameStart = 1'b0;
  logic        bitStrobe;
  logic [3:0]  bitIndex;
  logic        frameActive;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  jitter_baud_gen u_dut (
    .clk(clk), .rstN(rstN), .divisorReg(divisorReg),
    .jitterPattern(jitterPattern), .dataBitsSel(dataBitsSel),
    .paritySel(paritySel), .stopBitsSel(stopBitsSel), .rxMode(rxMode),
    .frameStart(frameStart), .bitStrobe(bitStrobe), .bitIndex(bitIndex),
    .frameActive(frameActive)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int bitWidth(input int i, input int d, input logic [23:0] pat);
    logic [1:0] c;
    c = pat[2*i +: 2];
    if (c == 2'b01) return 17 * d;
    if (c == 2'b10) return 15 * d;
    return 16 * d;
  endfunction

  task automatic runFrame(input int div, input logic [23:0] pat, input int ds,
                          input int par, input int ss, input bit rx,
                          input int restartAfter, input string req);
    int got [16];
    int gotIdx [16];
    int expT [16];
    int nStrb, endTick, n, len, cum, d, k, firstIdx;
    d = div + 1;
    @(negedge clk);
    divisorReg = 8'(div); jitterPattern = pat; dataBitsSel = 2'(ds);
    paritySel = 3'(par); stopBitsSel = 1'(ss); rxMode = rx;
    frameStart = 1'b1;
    if (restartAfter > 0) begin
      @(negedge clk); frameStart = 1'b0;
      repeat (restartAfter - 1) @(negedge clk);
      frameStart = 1'b1;
    end
    @(negedge clk); frameStart = 1'b0;
    n = 1; nStrb = 0; endTick = 0; firstIdx = bitIndex;
    while (n <= 60000) begin
      if (bitStrobe) begin
        if (nStrb < 16) begin got[nStrb] = n; gotIdx[nStrb] = bitIndex; end
        nStrb++;
      end
      if (!frameActive) begin endTick = n; break; end
      @(negedge clk); n++;
    end
    len = 7 + ds + ((par != 0) ? 1 : 0) + ss;
    cum = 0;
    for (int i = 0; i < len; i++) begin
      int w;
      w = bitWidth(i, d, pat);
      expT[i] = rx ? cum + ((w / d) / 2) * d : cum + w;
      cum += w;
    end
    check(req, "index after start", firstIdx, 0);
    check(req, "strobe count", nStrb, len);
    k = 0;
    for (int i = 0; i < len && i < nStrb; i++) begin
      if (got[i] != expT[i]) begin k = i; break; end
    end
    check(req, $sformatf("strobe tick of bit %0d", k), (nStrb > k) ? got[k] : -1, expT[k]);
    k = 0;
    for (int i = 0; i < len && i < nStrb; i++) begin
      if (gotIdx[i] != i) begin k = i; break; end
    end
    check(req, "index at strobe", (nStrb > k) ? gotIdx[k] : -1, k);
    check(req, "frame end tick", endTick, cum + 1);
    @(negedge clk);
    check(req, "index held after frame", bitIndex, len - 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd7);
    repeat (3) @(negedge clk);
    check("R1", "strobe after reset", bitStrobe, 0);
    check("R1", "active after reset", frameActive, 0);
    check("R1", "index after reset", bitIndex, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "active idle", frameActive, 0);

    runFrame(3,   24'h000000, 3, 0, 0, 1'b0, 0, "R3 nominal tx");
    runFrame(255, 24'h000000, 0, 0, 0, 1'b0, 0, "R3 max divisor");
    runFrame(2,   24'h555555, 3, 1, 1, 1'b0, 0, "R4 widen tx");
    runFrame(2,   24'hAAAAAA, 3, 2, 1, 1'b0, 0, "R4 narrow tx");
    runFrame(1,   24'hFFFFFF, 2, 3, 0, 1'b0, 0, "R4 code 11");
    runFrame(2,   24'h000000, 1, 4, 1, 1'b1, 0, "R6 nominal rx");
    runFrame(0,   24'hAAAAAA, 3, 0, 0, 1'b1, 0, "R6 narrow rx div1");
    runFrame(255, 24'h555555, 0, 0, 0, 1'b1, 0, "R6 widen rx max div");
    runFrame(1,   24'h554000, 0, 0, 0, 1'b0, 0, "R9 codes beyond frame");
    runFrame(2,   24'h000000, 3, 1, 1, 1'b0, 37, "R8 restart");
    runFrame(1,   24'h001234, 2, 2, 1, 1'b1, 53, "R8 restart rx");
    runFrame(0,   24'h000000, 0, 0, 0, 1'b0, 0, "R2 shortest");
    runFrame(0,   24'h000000, 3, 1, 1, 1'b0, 0, "R2 longest");

    for (int r = 0; r < 20; r++) begin
      runFrame(int'($urandom % 4), 24'($urandom), int'($urandom % 4),
               int'($urandom % 5), int'($urandom % 2), 1'($urandom % 2),
               0, $sformatf("R5 R7 random %0d", r));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule